// File: doc/BRIEF.md
# External Trigger Unit

This block gives meaning to a single shared input pin according to the operating mode of a serial-bus terminal. In remote-terminal mode the pin is a level: while it is low, the subsystem-flag bit that goes into the terminal's status word is set. In bus-controller and word-monitor modes the pin is an edge source, and a qualified rising edge becomes a one-cycle start pulse. In enhanced bus-controller mode, a rising edge that arrives while a wait-for-trigger instruction is pending becomes a one-cycle release pulse, and the sequencer moves on to its next instruction. In message-monitor mode the pin is ignored.

Software owns a small configuration register. It holds a trigger-enable bit that qualifies the start pulses and a subsystem-flag bit. The flag bit is active low: writing 0 raises the status flag. The register always reads back exactly what was last written, whatever the pin does. The pin is asynchronous. It passes through a synchronizer that resets to the high idle level, so a pin that is already high when reset is released does not produce a spurious edge.

Top module: `ext_trig_unit`

## Requirements
- R1: During and after reset all four outputs are 0 and the register reads 16'h0100. The synchronizer resets high, so a pin held high through reset never produces a pulse, even in enhanced mode with the wait input high.
- R2: With mode code 3'd0 (remote terminal), `ss_flag` is 1 whenever the synchronized pin is low or register bit 8 is 0. A pin change reaches `ss_flag` on the third rising clock edge after it.
- R3: `cfg_rd_data` always equals the last value written through `cfg_wr_en`/`cfg_wr_data`, one cycle after the write, regardless of the pin level.
- R4: With mode code 3'd1 (bus controller) and register bit 7 set, a low-to-high pin transition gives `frame_start` high for exactly one cycle, on the third rising clock edge after the transition. With bit 7 clear there is no pulse.
- R5: With mode code 3'd2 (enhanced bus controller) and `wait_active` high, a rising pin edge gives a one-cycle `wait_go` pulse with the same latency as R4. Bit 7 has no effect on this pulse.
- R6: In mode 3'd2, a rising edge that is detected while `wait_active` is low is dropped. Raising `wait_active` afterwards does not produce `wait_go`.
- R7: With mode code 3'd3 (word monitor) and bit 7 set, a rising edge gives a one-cycle `mon_start` pulse with the same latency as R4. With bit 7 clear there is no pulse.
- R8: With mode code 3'd4 (message monitor), or any code from 3'd5 to 3'd7, the pin drives no output.
- R9: Falling edges and steady levels produce no pulse. At most one pulse output is high in any cycle, and `ss_flag` is 0 outside mode 3'd0.
- R10: A register write in the same cycle that an edge is qualified does not affect that edge: the edge is judged against the register contents before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_pin | input | 1 | Shared asynchronous external pin |
| mode | input | 3 | Terminal mode code (0 RT, 1 BC, 2 enhanced BC, 3 word monitor, 4 message monitor) |
| wait_active | input | 1 | High while a wait-for-trigger instruction is pending |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wr_data | input | 16 | Configuration write data (bit 7 trigger enable, bit 8 flag, active low) |
| cfg_rd_data | output | 16 | Configuration register readback |
| frame_start | output | 1 | One-cycle bus-controller frame start |
| wait_go | output | 1 | One-cycle release of a pending wait instruction |
| mon_start | output | 1 | One-cycle word-monitor start |
| ss_flag | output | 1 | Subsystem-flag bit for the status word |

## Verification
A software write to the configuration register can land in the same cycle that a synchronized rising edge is being qualified. The bench sets up this collision by timing the write strobe so that it is captured on the same clock edge as the pulse register. It then checks that the pulse follows the register contents from before the write in both directions: a newly set enable yields no pulse, and a newly cleared enable still yields one. In that same cycle it also checks that the readback already shows the new value.

// File: rtl/ext_trig_pkg.sv
package ext_trig_pkg;
  typedef enum logic [2:0] {
    MODE_RT   = 3'd0,
    MODE_BC   = 3'd1,
    MODE_EBC  = 3'd2,
    MODE_WMON = 3'd3,
    MODE_MMON = 3'd4
  } term_mode_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES < 2) begin : g_bad_depth
      initial $error("trig_sync needs at least two stages");
    end
  endgenerate

  // Reset to the idle-high level so a high pin at release is not an edge (R1)
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;

  assert_rise_single_R9: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/trig_cfg_reg.sv
module trig_cfg_reg #(
  parameter int           W         = 16,
  parameter int           EN_BIT    = 7,
  parameter int           FLAG_BIT  = 8,
  parameter logic [W-1:0] RESET_VAL = 16'h0100
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] rd_data_o,
  output logic         trig_en_o,
  output logic         flag_n_o
);
  logic [W-1:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst)          reg_q <= RESET_VAL;
    else if (wr_en_i) reg_q <= wr_data_i;
  end

  assign rd_data_o = reg_q;
  assign trig_en_o = reg_q[EN_BIT];
  assign flag_n_o  = reg_q[FLAG_BIT];

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/trig_dispatch.sv
module trig_dispatch
  import ext_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode_i,
  input  logic       trig_en_i,
  input  logic       flag_n_i,
  input  logic       wait_active_i,
  input  logic       level_i,
  input  logic       rise_i,
  output logic       frame_start_o,
  output logic       wait_go_o,
  output logic       mon_start_o,
  output logic       ss_flag_o
);
  logic is_rt, is_bc, is_ebc, is_wmon;

  always_comb begin
    is_rt   = (mode_i == MODE_RT);
    is_bc   = (mode_i == MODE_BC);
    is_ebc  = (mode_i == MODE_EBC);
    is_wmon = (mode_i == MODE_WMON);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_start_o <= 1'b0;
      wait_go_o     <= 1'b0;
      mon_start_o   <= 1'b0;
      ss_flag_o     <= 1'b0;
    end else begin
      frame_start_o <= rise_i & trig_en_i & is_bc;
      wait_go_o     <= rise_i & wait_active_i & is_ebc;
      mon_start_o   <= rise_i & trig_en_i & is_wmon;
      ss_flag_o     <= is_rt & (~level_i | ~flag_n_i);
    end
  end

  assert_one_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frame_start_o, wait_go_o, mon_start_o}));
  assert_flag_rt_only_R2: assert property (@(posedge clk) disable iff (rst)
    ss_flag_o |-> ($past(mode_i) == MODE_RT));
  assert_start_qualified_R4: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |-> ($past(trig_en_i) && $past(mode_i) == MODE_BC));
  assert_go_needs_wait_R6: assert property (@(posedge clk) disable iff (rst)
    wait_go_o |-> $past(wait_active_i));
  assert_mon_qualified_R7: assert property (@(posedge clk) disable iff (rst)
    mon_start_o |-> ($past(trig_en_i) && $past(mode_i) == MODE_WMON));
  assert_quiet_modes_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_i) >= 3'd4) |-> !(frame_start_o || wait_go_o || mon_start_o || ss_flag_o));
endmodule

// File: rtl/ext_trig_unit.sv
module ext_trig_unit #(
  parameter int               SYNC_STAGES = 2,
  parameter int               CFG_W       = 16,
  parameter int               EN_BIT      = 7,
  parameter int               FLAG_BIT    = 8,
  parameter logic [CFG_W-1:0] CFG_RESET   = 16'h0100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_pin,
  input  logic [2:0]       mode,
  input  logic             wait_active,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  output logic [CFG_W-1:0] cfg_rd_data,
  output logic             frame_start,
  output logic             wait_go,
  output logic             mon_start,
  output logic             ss_flag
);
  logic pin_level, pin_rise, trig_en, flag_n;

  trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(trig_pin),
    .level_o(pin_level), .rise_o(pin_rise)
  );

  trig_cfg_reg #(
    .W(CFG_W), .EN_BIT(EN_BIT), .FLAG_BIT(FLAG_BIT), .RESET_VAL(CFG_RESET)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en_i(cfg_wr_en), .wr_data_i(cfg_wr_data),
    .rd_data_o(cfg_rd_data), .trig_en_o(trig_en), .flag_n_o(flag_n)
  );

  trig_dispatch u_disp (
    .clk(clk), .rst(rst), .mode_i(mode), .trig_en_i(trig_en),
    .flag_n_i(flag_n), .wait_active_i(wait_active),
    .level_i(pin_level), .rise_i(pin_rise),
    .frame_start_o(frame_start), .wait_go_o(wait_go),
    .mon_start_o(mon_start), .ss_flag_o(ss_flag)
  );
endmodule

// File: tb/test_ext_trig_unit.sv
`timescale 1ns/1ps
module test_ext_trig_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig_pin = 1'b1;
  logic [2:0]  mode = 3'd2;
  logic        wait_active = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_wr_data = '0;
  logic [15:0] cfg_rd_data;
  logic        frame_start, wait_go, mon_start, ss_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_trig_unit i_ext_trig_unit (
    .clk(clk), .rst(rst), .trig_pin(trig_pin), .mode(mode),
    .wait_active(wait_active), .cfg_wr_en(cfg_wr_en),
    .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .frame_start(frame_start), .wait_go(wait_go),
    .mon_start(mon_start), .ss_flag(ss_flag)
  );

  // vector: {mode[2:0], en, flag_n, wait, exp_frame, exp_go, exp_mon}
  localparam int NV = 11;
  localparam logic [8:0] VEC [NV] = '{
    9'b000_1_1_0_000,  // R2 RT, flag not written
    9'b000_0_0_0_000,  // R2 RT, flag written
    9'b001_1_1_0_100,  // R4 BC enabled
    9'b001_0_1_0_000,  // R4 BC disabled
    9'b010_0_1_1_010,  // R5 enhanced, wait pending, enable clear
    9'b010_1_1_0_000,  // R6 enhanced, no wait
    9'b011_1_1_0_001,  // R7 word monitor enabled
    9'b011_0_1_1_000,  // R7 word monitor disabled
    9'b100_1_1_1_000,  // R8 message monitor
    9'b111_1_1_1_000,  // R8 unused code
    9'b001_1_1_1_100   // R4 BC with wait high
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_cfg(input logic en, input logic flag_n);
    cfg_wr_data = {7'h2A, flag_n, en, 7'h15};
    cfg_wr_en   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en   = 1'b0;
  endtask

  function automatic logic [3:0] outs();
    return {frame_start, wait_go, mon_start, ss_flag};
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] pulses;
    // R1: pin high through reset, enhanced mode with wait pending
    cyc(3);
    chk("R1 outputs in reset", {28'd0, outs()}, 32'd0);
    rst = 1'b0;
    pulses = '0;
    for (int k = 0; k < 6; k++) begin
      cyc(1);
      pulses |= outs();
    end
    chk("R1 no false edge after reset", {28'd0, pulses}, 32'd0);
    chk("R1 reset readback", {16'd0, cfg_rd_data}, 32'h0100);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [2:0] m;
      logic en, fl, wt;
      m  = VEC[v][8:6];
      en = VEC[v][5];
      fl = VEC[v][4];
      wt = VEC[v][3];
      trig_pin = 1'b0;
      mode = m;
      wait_active = wt;
      wr_cfg(en, fl);
      cyc(4);
      chk($sformatf("R2 flag with pin low v%0d", v), {31'd0, ss_flag}, {31'd0, m == 3'd0});
      chk($sformatf("R3 readback v%0d", v), {16'd0, cfg_rd_data}, {16'd0, 7'h2A, fl, en, 7'h15});
      trig_pin = 1'b1;
      cyc(3);
      chk($sformatf("R4 R5 R7 pulse v%0d", v), {29'd0, frame_start, wait_go, mon_start},
          {29'd0, VEC[v][2:0]});
      chk($sformatf("R2 R9 flag with pin high v%0d", v), {31'd0, ss_flag},
          {31'd0, (m == 3'd0) && !fl});
      cyc(1);
      chk($sformatf("R9 single-cycle pulse v%0d", v), {29'd0, frame_start, wait_go, mon_start}, 32'd0);
      chk($sformatf("R3 readback after pin v%0d", v), {16'd0, cfg_rd_data}, {16'd0, 7'h2A, fl, en, 7'h15});
    end

    // R2 latency in remote-terminal mode
    mode = 3'd0;
    wr_cfg(1'b0, 1'b1);
    cyc(4);
    trig_pin = 1'b0;
    cyc(2);
    chk("R2 flag not yet set after two edges", {31'd0, ss_flag}, 32'd0);
    cyc(1);
    chk("R2 flag set on third edge", {31'd0, ss_flag}, 32'd1);
    trig_pin = 1'b1;
    cyc(3);
    chk("R2 flag clears with pin high", {31'd0, ss_flag}, 32'd0);

    // R9 falling edge and steady low in BC mode
    mode = 3'd1;
    wr_cfg(1'b1, 1'b1);
    cyc(2);
    trig_pin = 1'b0;
    pulses = '0;
    for (int k = 0; k < 6; k++) begin
      cyc(1);
      pulses |= outs();
    end
    chk("R9 falling edge gives no output", {28'd0, pulses}, 32'd0);

    // R6 dropped edge in enhanced mode
    mode = 3'd2;
    wait_active = 1'b0;
    trig_pin = 1'b1;
    cyc(4);
    wait_active = 1'b1;
    pulses = '0;
    for (int k = 0; k < 6; k++) begin
      cyc(1);
      pulses |= outs();
    end
    chk("R6 late wait does not release", {28'd0, pulses}, 32'd0);

    // R10 write colliding with edge qualification
    mode = 3'd1;
    wait_active = 1'b0;
    trig_pin = 1'b0;
    wr_cfg(1'b0, 1'b1);
    cyc(4);
    trig_pin = 1'b1;
    cyc(2);
    cfg_wr_data = 16'h0180;
    cfg_wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    chk("R10 enable written in edge cycle ignored", {31'd0, frame_start}, 32'd0);
    chk("R10 readback shows new enable", {16'd0, cfg_rd_data}, 32'h0180);
    trig_pin = 1'b0;
    cyc(4);
    trig_pin = 1'b1;
    cyc(2);
    cfg_wr_data = 16'h0100;
    cfg_wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    chk("R10 enable cleared in edge cycle still pulses", {31'd0, frame_start}, 32'd1);
    cyc(1);
    chk("R4 pulse lasts one cycle", {31'd0, frame_start}, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule